// File: doc/BRIEF.md
# Upstream Port Failover Mode Controller

This block decides which of two operating modes an upstream port pair runs in: normal mode or failover mode. It reports the mode in effect as a status bit. A mode switch can start from any of three sources. The first is a software write to the control word. The second is the level on an external failover pin. The third is an expiry pulse from a watchdog counter held elsewhere.

When a switch starts, the block raises a one-cycle launch strobe together with the requested mode and the source that caused it. It then holds a busy flag until the link-switching datapath answers with a done pulse. On that pulse the reported mode takes the target value and the block goes idle again. A request that arrives while busy is high is thrown away, not saved for later.

The pin is sampled straight from its pad through a synchronizer chain, whatever the pad is configured for. The pin compares its level with the current mode; it does not look for an edge. The timer always flips the mode.

Top module: `fovr_mode_ctrl`

## Requirements
- R1: After a synchronous reset, `cur_mode` is 0 (normal), `busy` is 0, `launch` is 0 and `launch_src` is 0.
- R2: A control write whose bit 0 (mode select) differs from `cur_mode`, made while idle, gives `launch`=1, `busy`=1, `launch_src`=1 and `tgt_mode` equal to the written bit on the next clock edge.
- R3: A control write whose mode-select bit equals `cur_mode` starts no switch.
- R4: With the pin enable (control bit 1) stored, a pin level that differs from `cur_mode` starts a switch toward that level (0 = normal, 1 = failover) with `launch_src`=2. A pin change made before clock edge N is acted on at edge N+2 (two synchronizer stages), so `launch` shows after edge N+2.
- R5: With the pin enable clear, the pin level has no effect.
- R6: With the timer enable (control bit 2) stored, a `wdog_expire` pulse while idle starts a switch to the opposite of `cur_mode`, with `launch_src`=3.
- R7: With the timer enable clear, `wdog_expire` has no effect.
- R8: While `busy` is 1, every request is dropped: `tgt_mode` holds, no launch occurs, and no dropped request takes effect after the switch completes.
- R9: `xfer_done` while busy copies `tgt_mode` into `cur_mode` and clears `busy` on the same edge. `xfer_done` while idle is ignored.
- R10: When sources request in the same cycle, software wins over the pin and the pin wins over the timer. Only one switch is launched.
- R11: `launch` is a single-cycle pulse, and `launch_src` is 0 in every cycle without a launch. The enable bits are taken from a write on every write, and they take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 3 | Control word: bit0 mode select, bit1 pin enable, bit2 timer enable |
| fovr_pin | input | 1 | Asynchronous failover pin level |
| wdog_expire | input | 1 | Watchdog expiry pulse |
| xfer_done | input | 1 | Done handshake from the link-switching datapath |
| cur_mode | output | 1 | Current mode: 0 normal, 1 failover |
| busy | output | 1 | Switch in progress |
| launch | output | 1 | One-cycle strobe when a switch starts |
| launch_src | output | 2 | Source of the launch: 1 software, 2 pin, 3 timer, 0 none |
| tgt_mode | output | 1 | Mode being switched to |

## Verification
The bench sends in conflicting requests while a switch is active. A design that queued these would launch a second switch right after `xfer_done`. It also lines up a software write, a synchronized pin change and a watchdog pulse on the same edge, to expose a wrong priority order or a double launch. The pin path is timed edge by edge, so a synchronizer that is one stage short or long shows up as a launch on the wrong cycle. Done pulses given while idle, and timer switches in both directions, catch a mode that moves without a handshake or a timer that does not toggle.

// File: rtl/fovr_pkg.sv
package fovr_pkg;

    localparam int CTL_W = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SW   = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_TMR  = 2'd3
    } fovr_src_e;

    // control word layout: {timer enable, pin enable, mode select}
    typedef struct packed {
        logic tmr_en;
        logic pin_en;
        logic mode_sel;
    } fovr_ctl_t;

    typedef struct packed {
        logic      valid;
        fovr_src_e src;
        logic      mode;
    } fovr_req_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } fovr_state_e;

    localparam fovr_req_t REQ_NONE = '{valid: 1'b0, src: SRC_NONE, mode: 1'b0};

    function automatic fovr_req_t mk_req(input fovr_src_e s, input logic m);
        fovr_req_t r;
        r.valid = 1'b1;
        r.src   = s;
        r.mode  = m;
        return r;
    endfunction

    // fixed priority: software, then pin, then timer
    function automatic fovr_req_t pick_req(input fovr_req_t sw,
                                           input fovr_req_t pin,
                                           input fovr_req_t tmr);
        if (sw.valid)       return sw;
        else if (pin.valid) return pin;
        else if (tmr.valid) return tmr;
        else                return REQ_NONE;
    endfunction

endpackage

// File: rtl/fovr_pin_sync.sv
module fovr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= pin_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fovr_ctl_regs.sv
module fovr_ctl_regs
    import fovr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             cur_mode,
    output logic             pin_en,
    output logic             tmr_en,
    output fovr_req_t        sw_req
);
    fovr_ctl_t wr_word;
    assign wr_word = fovr_ctl_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_en <= 1'b0;
            tmr_en <= 1'b0;
        end else if (wr_en) begin
            pin_en <= wr_word.pin_en;
            tmr_en <= wr_word.tmr_en;
        end
    end

    always_comb begin
        sw_req = REQ_NONE;
        if (wr_en && (wr_word.mode_sel != cur_mode))
            sw_req = mk_req(SRC_SW, wr_word.mode_sel);
    end

    // R11: enables follow the last write, one cycle later
    a_r11_enable_follows_write: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (pin_en == $past(wr_data[1])) && (tmr_en == $past(wr_data[2])));
endmodule

// File: rtl/fovr_arbiter.sv
module fovr_arbiter
    import fovr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fovr_req_t sw_req,
    input  logic      pin_lvl,
    input  logic      pin_en,
    input  logic      wdog_hit,
    input  logic      tmr_en,
    input  logic      cur_mode,
    output fovr_req_t win
);
    fovr_req_t pin_req, tmr_req;

    always_comb begin
        pin_req = REQ_NONE;
        if (pin_en && (pin_lvl != cur_mode))
            pin_req = mk_req(SRC_PIN, pin_lvl);
        tmr_req = REQ_NONE;
        if (tmr_en && wdog_hit)
            tmr_req = mk_req(SRC_TMR, ~cur_mode);
        win = pick_req(sw_req, pin_req, tmr_req);
    end

    // R10: software request always wins when present
    a_r10_sw_first: assert property (@(posedge clk) disable iff (rst)
        sw_req.valid |-> (win.src == SRC_SW) && (win.mode == sw_req.mode));
    // R10: pin beats timer when no software request
    a_r10_pin_over_tmr: assert property (@(posedge clk) disable iff (rst)
        (!sw_req.valid && pin_en && (pin_lvl != cur_mode)) |-> (win.src == SRC_PIN));
endmodule

// File: rtl/fovr_seq.sv
module fovr_seq
    import fovr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fovr_req_t req,
    input  logic      done,
    output logic      cur_mode,
    output logic      busy,
    output logic      launch,
    output fovr_src_e launch_src,
    output logic      tgt_mode
);
    fovr_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_mode   <= 1'b0;
            tgt_mode   <= 1'b0;
            launch     <= 1'b0;
            launch_src <= SRC_NONE;
        end else begin
            launch     <= 1'b0;
            launch_src <= SRC_NONE;
            case (state_q)
                ST_IDLE: begin
                    if (req.valid) begin
                        state_q    <= ST_BUSY;
                        tgt_mode   <= req.mode;
                        launch     <= 1'b1;
                        launch_src <= req.src;
                    end
                end
                ST_BUSY: begin
                    if (done) begin
                        cur_mode <= tgt_mode;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_BUSY);

    // R9: mode moves only on a done handshake while busy
    a_r9_mode_on_done: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != $past(cur_mode)) |-> $past(done && busy));
    // R2: a launch always comes with busy
    a_r2_launch_busy: assert property (@(posedge clk) disable iff (rst)
        launch |-> busy);
    // R8: target frozen during an active switch
    a_r8_tgt_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tgt_mode));
    // R11: launch is a single pulse
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);
    // R6: a timer launch always flips the mode
    a_r6_timer_flips: assert property (@(posedge clk) disable iff (rst)
        (launch && launch_src == SRC_TMR) |-> (tgt_mode != cur_mode));
endmodule

// File: rtl/fovr_mode_ctrl.sv
module fovr_mode_ctrl
    import fovr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    input  logic             fovr_pin,
    input  logic             wdog_expire,
    input  logic             xfer_done,
    output logic             cur_mode,
    output logic             busy,
    output logic             launch,
    output logic [1:0]       launch_src,
    output logic             tgt_mode
);
    logic      pin_lvl, pin_en, tmr_en;
    fovr_req_t sw_req, win;
    fovr_src_e src_e;

    fovr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_async(fovr_pin), .pin_sync(pin_lvl)
    );

    fovr_ctl_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .cur_mode(cur_mode), .pin_en(pin_en), .tmr_en(tmr_en), .sw_req(sw_req)
    );

    fovr_arbiter u_arb (
        .clk(clk), .rst(rst), .sw_req(sw_req), .pin_lvl(pin_lvl),
        .pin_en(pin_en), .wdog_hit(wdog_expire), .tmr_en(tmr_en),
        .cur_mode(cur_mode), .win(win)
    );

    fovr_seq u_seq (
        .clk(clk), .rst(rst), .req(win), .done(xfer_done),
        .cur_mode(cur_mode), .busy(busy), .launch(launch),
        .launch_src(src_e), .tgt_mode(tgt_mode)
    );

    assign launch_src = src_e;
endmodule

// File: tb/test_fovr_mode_ctrl.sv
module test_fovr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr_en = 1'b0;
    logic [2:0] ctl_wr_data = 3'b000;
    logic       fovr_pin = 1'b0;
    logic       wdog_expire = 1'b0;
    logic       xfer_done = 1'b0;
    logic       cur_mode, busy, launch, tgt_mode;
    logic [1:0] launch_src;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    fovr_mode_ctrl i_fovr_mode_ctrl (
        .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .fovr_pin(fovr_pin), .wdog_expire(wdog_expire), .xfer_done(xfer_done),
        .cur_mode(cur_mode), .busy(busy), .launch(launch),
        .launch_src(launch_src), .tgt_mode(tgt_mode)
    );

    // behavioural reference
    int m_mode, m_busy, m_tgt, m_launch, m_src, m_pen, m_ten, m_s1, m_s2;

    always @(posedge clk) begin
        int req_src, req_mode;
        if (rst) begin
            m_mode = 0; m_busy = 0; m_tgt = 0; m_launch = 0; m_src = 0;
            m_pen = 0; m_ten = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            req_src = 0; req_mode = 0;
            if (ctl_wr_en && int'(ctl_wr_data[0]) != m_mode) begin
                req_src = 1; req_mode = int'(ctl_wr_data[0]);
            end else if (m_pen != 0 && m_s2 != m_mode) begin
                req_src = 2; req_mode = m_s2;
            end else if (m_ten != 0 && wdog_expire) begin
                req_src = 3; req_mode = 1 - m_mode;
            end
            m_launch = 0; m_src = 0;
            if (m_busy != 0) begin
                if (xfer_done) begin m_mode = m_tgt; m_busy = 0; end
            end else if (req_src != 0) begin
                m_busy = 1; m_launch = 1; m_src = req_src; m_tgt = req_mode;
            end
            if (ctl_wr_en) begin
                m_pen = int'(ctl_wr_data[1]);
                m_ten = int'(ctl_wr_data[2]);
            end
            m_s2 = m_s1;
            m_s1 = int'(fovr_pin);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9 model cur_mode", int'(cur_mode), m_mode);
            chk("R8 model busy", int'(busy), m_busy);
            chk("R11 model launch", int'(launch), m_launch);
            chk("R10 model launch_src", int'(launch_src), m_src);
            chk("R6 model tgt_mode", int'(tgt_mode), m_tgt);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // drive at the falling edge, then wait n rising edges and settle
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic wdog_pulse();
        @(negedge clk);
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        edges(3);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        chk("R1 cur_mode", int'(cur_mode), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 launch", int'(launch), 0);
        chk("R1 launch_src", int'(launch_src), 0);

        // R2 software launch to failover
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = 3'b001;
        edges(1);
        chk("R2 launch", int'(launch), 1);
        chk("R2 busy", int'(busy), 1);
        chk("R2 src", int'(launch_src), 1);
        chk("R2 tgt", int'(tgt_mode), 1);
        @(negedge clk); ctl_wr_en = 1'b0;
        edges(1);
        chk("R11 pulse ends", int'(launch), 0);
        // R8 conflicting write while busy is dropped
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = 3'b000;
        @(negedge clk); ctl_wr_en = 1'b0;
        chk("R8 tgt held", int'(tgt_mode), 1);
        chk("R8 no launch", int'(launch), 0);
        // R9 done completes the switch
        @(negedge clk); xfer_done = 1'b1;
        edges(1);
        chk("R9 mode", int'(cur_mode), 1);
        chk("R9 busy clear", int'(busy), 0);
        @(negedge clk); xfer_done = 1'b0;
        edges(2);
        chk("R8 not queued", int'(busy), 0);

        // R3 same-mode write
        wr(3'b001);
        edges(1);
        chk("R3 no switch", int'(busy), 0);
        // R9 idle done ignored
        done_pulse();
        edges(1);
        chk("R9 idle done", int'(cur_mode), 1);

        // R5 pin disabled, pin low differs from mode 1
        @(negedge clk); fovr_pin = 1'b0;
        edges(5);
        chk("R5 pin ignored", int'(busy), 0);
        // R4 enable pin, mode bit unchanged
        wr(3'b011);
        edges(1);
        chk("R4 pin src", int'(launch_src), 2);
        chk("R4 pin tgt", int'(tgt_mode), 0);
        done_pulse();
        edges(1);
        chk("R4 to normal", int'(cur_mode), 0);
        // R4 two-stage latency
        @(negedge clk); fovr_pin = 1'b1;
        edges(2);
        chk("R4 not before 3rd edge", int'(busy), 0);
        edges(1);
        chk("R4 launch on 3rd edge", int'(launch), 1);
        done_pulse();
        wr(3'b001);

        // R7 timer disabled
        @(negedge clk); fovr_pin = 1'b0;
        wdog_pulse();
        edges(1);
        chk("R7 timer ignored", int'(busy), 0);
        // R6 timer toggles both ways
        wr(3'b101);
        wdog_pulse();
        chk("R6 src", int'(launch_src), 3);
        chk("R6 tgt", int'(tgt_mode), 0);
        done_pulse();
        wdog_pulse();
        chk("R6 tgt back", int'(tgt_mode), 1);
        done_pulse();
        edges(1);
        chk("R6 mode", int'(cur_mode), 1);

        // R10 software beats timer (pin level low, pin enable not yet stored)
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = 3'b110; wdog_expire = 1'b1;
        edges(1);
        chk("R10 sw wins", int'(launch_src), 1);
        @(negedge clk); ctl_wr_en = 1'b0; wdog_expire = 1'b0;
        done_pulse();
        // R10 pin beats timer: pin rises, wdog arrives at the pin's launch edge
        @(negedge clk); fovr_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); wdog_expire = 1'b1;
        edges(1);
        chk("R10 pin wins", int'(launch_src), 2);
        chk("R10 pin tgt", int'(tgt_mode), 1);
        @(negedge clk); wdog_expire = 1'b0;
        done_pulse();

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            ctl_wr_en   = ($urandom % 30) == 0;
            ctl_wr_data = 3'($urandom);
            if (($urandom % 50) == 0) fovr_pin = ~fovr_pin;
            wdog_expire = ($urandom % 40) == 0;
            xfer_done   = ($urandom % 5) == 0;
        end
        @(negedge clk);
        ctl_wr_en = 1'b0; wdog_expire = 1'b0; xfer_done = 1'b0;
        edges(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule